// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block lets host logic perform a single read or write of 8, 16, 32, 48 or 64 bits to a register that sits behind a paged, indirect management window. The window is reached only through 16-bit management transactions at a fixed device address. The block turns one wide request into the needed series of transactions. It can select the page, transfer the data words, write a command word, poll for completion and gather the read words. It sends these transactions over a simple request/acknowledge port to a serial management bus master.

The block keeps a copy of the page it last selected, so a page write is issued only when the requested page changes. Completion is polled a bounded number of times, with a programmable idle gap between polls. Running out of polls, or an error on any management write, ends the operation with an error flag. The result is a one-cycle done pulse that carries the error flag and the read data, zero-extended to 64 bits.

Top module: `paged_reg_seq`

## Requirements
- R1: When the requested page differs from the cached page, the first transaction is a write to address 0x10 with data (page<<8)|1. After that write succeeds, the cache holds the new page. When the pages are equal, no write to 0x10 is issued.
- R2: After reset the cached page is 0xFF, so the first access to any other page always begins with a page write.
- R3: A write operation sends its data words to addresses 0x18, 0x19, ... in turn, least significant word first. The word count is 1 for 8- and 16-bit sizes, 2 for 32-bit, 3 for 48-bit and 4 for 64-bit. It then writes address 0x11 with (reg<<8)|1.
- R4: A read operation writes 0x11 with (reg<<8)|2 before it reads any data word. It then reads the data words from the highest address down to 0x18, each one shifted in below the earlier ones. For the 8-bit size only the low byte of the 0x18 word is returned.
- R5: Completion is polled by reading 0x11 until bits 1:0 are both zero. A responder that acknowledges one cycle after each request sees successive poll requests poll_gap+4 cycles apart.
- R6: If 5 polls in a row report a busy bit, the operation ends with err=1 and rdata=0, and no data word is read.
- R7: An error reported on any management write (page, data or command) ends the operation at once with err=1 and rdata=0, and no further transaction is issued. A failed page write leaves the cache unchanged. An error flag on a management read is ignored.
- R8: Each operation ends with done high for exactly one cycle, together with err and rdata. A successful write returns rdata=0.
- R9: A request is taken only while ready is high (idle). A request made while an operation is running is ignored.
- R10: mg_req, mg_write, mg_addr and mg_wdata stay constant from the rise of mg_req until mg_ack. mg_req is then low for at least one cycle.
- R11: The req_size encoding is 0=8, 1=16, 2=32, 3=48 and 4=64 bits. The codes 5 to 7 act as 64 bits.
- R12: After reset, ready=1, done=0 and mg_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an operation (taken while ready) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size code |
| req_page | input | 8 | Target page |
| req_reg | input | 8 | Target register within the page |
| req_wdata | input | 64 | Write data, low bits used for narrow sizes |
| poll_gap | input | 16 | Idle cycles added between completion polls |
| ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| rdata | output | 64 | Read data, zero-extended, valid with done |
| mg_req | output | 1 | Management transaction request |
| mg_write | output | 1 | Transaction direction, 1 = write |
| mg_addr | output | 5 | Management register address |
| mg_wdata | output | 16 | Management write word |
| mg_ack | input | 1 | Transaction completion, one cycle |
| mg_err | input | 1 | Transaction error, valid with mg_ack |
| mg_rdata | input | 16 | Management read word, valid with mg_ack |

## Verification
The assertions assume that the responder raises mg_ack for only one cycle at a time, and only while mg_req is high. They also assume that mg_err and mg_rdata matter only in that cycle. The bench responder acknowledges exactly one cycle after it sees a request, and it never acknowledges while the request is low. Requests are driven on falling edges and last one cycle. The busy pattern, the error address and the read-error flag are changed only between operations.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int MAX_WORDS = 4;

  typedef enum logic [2:0] {
    SZ_8  = 3'd0,
    SZ_16 = 3'd1,
    SZ_32 = 3'd2,
    SZ_48 = 3'd3,
    SZ_64 = 3'd4
  } size_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PAGE,
    S_WDATA,
    S_CMD,
    S_POLL,
    S_WAIT,
    S_RDATA,
    S_FIN
  } state_e;

  // number of 16-bit management words moved for a size code
  function automatic logic [2:0] words_for(input logic [2:0] sz);
    case (sz)
      SZ_8, SZ_16: words_for = 3'd1;
      SZ_32:       words_for = 3'd2;
      SZ_48:       words_for = 3'd3;
      default:     words_for = 3'd4;
    endcase
  endfunction

  // number of result bytes kept for a size code
  function automatic logic [3:0] bytes_for(input logic [2:0] sz);
    case (sz)
      SZ_8:    bytes_for = 4'd1;
      SZ_16:   bytes_for = 4'd2;
      SZ_32:   bytes_for = 4'd4;
      SZ_48:   bytes_for = 4'd6;
      default: bytes_for = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/seq_page_cache.sv
module seq_page_cache #(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] RESET_PAGE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] look_page,
  input  logic              upd,
  input  logic [PAGE_W-1:0] upd_page,
  output logic              hit
);

  logic [PAGE_W-1:0] cached;

  always_ff @(posedge clk) begin
    if (rst)      cached <= RESET_PAGE;
    else if (upd) cached <= upd_page;
  end

  assign hit = (look_page == cached);

  // R2: the cache starts from the unused page value
  a_r2_reset_page: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cached == RESET_PAGE));

  // R1: without an update the cached page keeps its value
  a_r1_cache_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(upd) && !$past(rst) |-> $stable(cached));

endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int GAP_W     = 16,
  parameter int MAX_POLLS = 5,
  localparam int POLL_W   = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             expired,
  input  logic             poll_clr,
  input  logic             poll_inc,
  output logic             last_poll
);

  logic [GAP_W-1:0]  gap_cnt;
  logic [POLL_W-1:0] poll_cnt;

  always_ff @(posedge clk) begin
    if (rst)                gap_cnt <= '0;
    else if (load)          gap_cnt <= gap;
    else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           poll_cnt <= '0;
    else if (poll_clr) poll_cnt <= '0;
    else if (poll_inc) poll_cnt <= poll_cnt + 1'b1;
  end

  assign expired   = (gap_cnt == '0);
  assign last_poll = (poll_cnt == POLL_W'(MAX_POLLS - 1));

  // R6: the poll counter never passes the retry limit
  a_r6_poll_bound: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < POLL_W'(MAX_POLLS));

  // R5: a loaded gap counts down by one per cycle
  a_r5_gap_down: assert property (@(posedge clk) disable iff (rst)
    !load && gap_cnt != '0 |=> gap_cnt == $past(gap_cnt) - 1'b1);

endmodule

// File: rtl/seq_word_lane.sv
module seq_word_lane #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  localparam int ACC_W = WORD_W * WORDS,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] shift_in,
  input  logic [2:0]        size,
  input  logic [ACC_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  sel,
  output logic [WORD_W-1:0] word_out,
  output logic [ACC_W-1:0]  result
);
  import seq_pkg::*;

  logic [ACC_W-1:0] acc;
  logic [3:0]       keep;

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (shift_en) acc <= {acc[ACC_W-WORD_W-1:0], shift_in};
  end

  assign word_out = wdata[sel*WORD_W +: WORD_W];
  assign keep     = bytes_for(size);

  always_comb begin
    for (int b = 0; b < ACC_W/8; b++) begin
      result[b*8 +: 8] = (4'(b) < keep) ? acc[b*8 +: 8] : 8'h00;
    end
  end

  // R4: each shift puts the new word into the low lane
  a_r4_shift_low: assert property (@(posedge clk) disable iff (rst)
    shift_en && !clear |=> acc[WORD_W-1:0] == $past(shift_in));

endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq #(
  parameter int WORD_W    = 16,
  parameter int PAGE_W    = 8,
  parameter int REG_W     = 8,
  parameter int GAP_W     = 16,
  parameter int MAX_POLLS = 5,
  parameter int MG_ADDR_W = 5,
  parameter logic [MG_ADDR_W-1:0] PAGE_ADDR = 5'h10,
  parameter logic [MG_ADDR_W-1:0] CMD_ADDR  = 5'h11,
  parameter logic [MG_ADDR_W-1:0] DATA_ADDR = 5'h18,
  parameter logic [PAGE_W-1:0]    RESET_PAGE = '1,
  localparam int ACC_W = WORD_W * seq_pkg::MAX_WORDS,
  localparam int IDX_W = $clog2(seq_pkg::MAX_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [2:0]           req_size,
  input  logic [PAGE_W-1:0]    req_page,
  input  logic [REG_W-1:0]     req_reg,
  input  logic [ACC_W-1:0]     req_wdata,
  input  logic [GAP_W-1:0]     poll_gap,
  output logic                 ready,
  output logic                 done,
  output logic                 err,
  output logic [ACC_W-1:0]     rdata,
  output logic                 mg_req,
  output logic                 mg_write,
  output logic [MG_ADDR_W-1:0] mg_addr,
  output logic [WORD_W-1:0]    mg_wdata,
  input  logic                 mg_ack,
  input  logic                 mg_err,
  input  logic [WORD_W-1:0]    mg_rdata
);
  import seq_pkg::*;

  state_e               state;
  logic                 op_write;
  logic [2:0]           op_size;
  logic [PAGE_W-1:0]    op_page;
  logic [REG_W-1:0]     op_reg;
  logic [ACC_W-1:0]     op_wdata;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     last_idx;
  logic                 done_q, err_q;
  logic [ACC_W-1:0]     rdata_q;
  logic                 req_q, wr_q;
  logic [MG_ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0]    wdat_q;

  logic                 page_hit, cache_upd;
  logic                 gap_load, gap_expired, poll_clr, poll_inc, last_poll;
  logic                 lane_clear, lane_shift;
  logic [WORD_W-1:0]    lane_word;
  logic [ACC_W-1:0]     lane_result;
  logic                 acked, busy_bits, accept;
  logic [WORD_W-1:0]    page_word, cmd_word;

  assign acked     = req_q && mg_ack;
  assign busy_bits = |mg_rdata[1:0];
  assign accept    = (state == S_IDLE) && req_valid;
  assign last_idx  = IDX_W'(words_for(op_size) - 3'd1);
  assign page_word = {op_page, {(WORD_W-PAGE_W-1){1'b0}}, 1'b1};
  assign cmd_word  = {op_reg, {(WORD_W-REG_W-2){1'b0}}, ~op_write, op_write};

  assign cache_upd  = (state == S_PAGE) && acked && !mg_err;
  assign poll_clr   = (state == S_CMD) && acked;
  assign poll_inc   = (state == S_POLL) && acked && busy_bits && !last_poll;
  assign gap_load   = poll_inc;
  assign lane_clear = accept;
  assign lane_shift = (state == S_RDATA) && acked;

  seq_page_cache #(.PAGE_W(PAGE_W), .RESET_PAGE(RESET_PAGE)) u_cache (
    .clk(clk), .rst(rst), .look_page(req_page),
    .upd(cache_upd), .upd_page(op_page), .hit(page_hit));

  seq_poll_timer #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk(clk), .rst(rst), .load(gap_load), .gap(poll_gap),
    .expired(gap_expired), .poll_clr(poll_clr), .poll_inc(poll_inc),
    .last_poll(last_poll));

  seq_word_lane #(.WORD_W(WORD_W), .WORDS(MAX_WORDS)) u_lane (
    .clk(clk), .rst(rst), .clear(lane_clear), .shift_en(lane_shift),
    .shift_in(mg_rdata), .size(op_size), .wdata(op_wdata), .sel(idx),
    .word_out(lane_word), .result(lane_result));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_write <= 1'b0;
      op_size  <= '0;
      op_page  <= '0;
      op_reg   <= '0;
      op_wdata <= '0;
      idx      <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
      req_q    <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_write <= req_write;
            op_size  <= req_size;
            op_page  <= req_page;
            op_reg   <= req_reg;
            op_wdata <= req_wdata;
            idx      <= '0;
            if (!page_hit)      state <= S_PAGE;
            else if (req_write) state <= S_WDATA;
            else                state <= S_CMD;
          end
        end
        S_PAGE: begin
          if (!req_q) begin
            req_q <= 1'b1; wr_q <= 1'b1; addr_q <= PAGE_ADDR; wdat_q <= page_word;
          end else if (mg_ack) begin
            req_q <= 1'b0;
            if (mg_err) begin
              done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
            end else begin
              state <= op_write ? S_WDATA : S_CMD;
            end
          end
        end
        S_WDATA: begin
          if (!req_q) begin
            req_q  <= 1'b1; wr_q <= 1'b1;
            addr_q <= DATA_ADDR + MG_ADDR_W'(idx);
            wdat_q <= lane_word;
          end else if (mg_ack) begin
            req_q <= 1'b0;
            if (mg_err) begin
              done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
            end else if (idx == last_idx) begin
              state <= S_CMD;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_CMD: begin
          if (!req_q) begin
            req_q <= 1'b1; wr_q <= 1'b1; addr_q <= CMD_ADDR; wdat_q <= cmd_word;
          end else if (mg_ack) begin
            req_q <= 1'b0;
            if (mg_err) begin
              done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
            end else begin
              state <= S_POLL;
            end
          end
        end
        S_POLL: begin
          if (!req_q) begin
            req_q <= 1'b1; wr_q <= 1'b0; addr_q <= CMD_ADDR; wdat_q <= '0;
          end else if (mg_ack) begin
            req_q <= 1'b0;
            if (!busy_bits) begin
              if (op_write) begin
                state <= S_FIN;
              end else begin
                idx   <= last_idx;
                state <= S_RDATA;
              end
            end else if (last_poll) begin
              done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (gap_expired) state <= S_POLL;
        end
        S_RDATA: begin
          if (!req_q) begin
            req_q  <= 1'b1; wr_q <= 1'b0;
            addr_q <= DATA_ADDR + MG_ADDR_W'(idx);
            wdat_q <= '0;
          end else if (mg_ack) begin
            req_q <= 1'b0;
            if (idx == '0) state <= S_FIN;
            else           idx   <= idx - 1'b1;
          end
        end
        S_FIN: begin
          done_q  <= 1'b1;
          err_q   <= 1'b0;
          rdata_q <= lane_result;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ready    = (state == S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rdata_q;
  assign mg_req   = req_q;
  assign mg_write = wr_q;
  assign mg_addr  = addr_q;
  assign mg_wdata = wdat_q;

  // R10: a pending transaction holds its fields until acknowledged
  a_r10_hold_fields: assert property (@(posedge clk) disable iff (rst)
    mg_req && !mg_ack |=> mg_req && $stable(mg_addr) && $stable(mg_write) && $stable(mg_wdata));

  // R10: the request drops for a cycle after each acknowledge
  a_r10_gap_after_ack: assert property (@(posedge clk) disable iff (rst)
    mg_req && mg_ack |=> !mg_req);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6, R7: a failed operation carries no data
  a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
    done && err |-> rdata == '0);

  // R1: a page-register transaction is a write with the enable bit set
  a_r1_page_word: assert property (@(posedge clk) disable iff (rst)
    mg_req && mg_addr == PAGE_ADDR |-> mg_write && mg_wdata[0]);

  // R3, R4: a command write carries exactly one operation bit
  a_r3_cmd_onehot: assert property (@(posedge clk) disable iff (rst)
    mg_req && mg_write && mg_addr == CMD_ADDR |-> $countones(mg_wdata[1:0]) == 1);

  // R9: no transaction is outstanding while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ready |-> !mg_req);

endmodule

// File: tb/tb_paged_reg_seq.sv
module tb_paged_reg_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [7:0]  pg;
    logic [7:0]  rg;
    logic [63:0] dat;
    logic [3:0]  busy;
    logic        exp_pw;
    logic [4:0]  exp_n;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 8'h02, 8'h30, 64'h0000_0000_0000_BEEF, 4'd0, 1'b1, 5'd4},
    '{1'b0, 3'd2, 8'h02, 8'h34, 64'h1111_2222_3333_4444, 4'd2, 1'b0, 5'd6},
    '{1'b1, 3'd4, 8'h05, 8'h00, 64'h0123_4567_89AB_CDEF, 4'd1, 1'b1, 5'd8},
    '{1'b0, 3'd3, 8'h05, 8'h10, 64'hAAAA_BBBB_CCCC_DDDD, 4'd0, 1'b0, 5'd5},
    '{1'b0, 3'd0, 8'h07, 8'h08, 64'h9999_8888_7777_12AB, 4'd4, 1'b1, 5'd8},
    '{1'b0, 3'd4, 8'h07, 8'h0C, 64'hFEDC_BA98_7654_3210, 4'd0, 1'b0, 5'd6},
    '{1'b0, 3'd1, 8'h07, 8'h20, 64'h0000_0000_0000_5555, 4'd5, 1'b0, 5'd6},
    '{1'b1, 3'd2, 8'h00, 8'h40, 64'h0000_0000_CAFE_F00D, 4'd0, 1'b1, 5'd5},
    '{1'b1, 3'd3, 8'h00, 8'h44, 64'h0000_1234_5678_9ABC, 4'd0, 1'b0, 5'd5},
    '{1'b0, 3'd6, 8'h00, 8'h48, 64'h0102_0304_0506_0708, 4'd0, 1'b0, 5'd6}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_size = '0;
  logic [7:0]  req_page = '0, req_reg = '0;
  logic [63:0] req_wdata = '0;
  logic [15:0] poll_gap = 16'd2;
  logic        ready, done, err;
  logic [63:0] rdata;
  logic        mg_req, mg_write;
  logic [4:0]  mg_addr;
  logic [15:0] mg_wdata;
  logic        mg_ack = 1'b0, mg_err = 1'b0;
  logic [15:0] mg_rdata = '0;

  paged_reg_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_page(req_page), .req_reg(req_reg),
    .req_wdata(req_wdata), .poll_gap(poll_gap), .ready(ready), .done(done),
    .err(err), .rdata(rdata), .mg_req(mg_req), .mg_write(mg_write),
    .mg_addr(mg_addr), .mg_wdata(mg_wdata), .mg_ack(mg_ack),
    .mg_err(mg_err), .mg_rdata(mg_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  // responder model
  logic [15:0] sl_regs [0:31];
  logic [3:0]  sl_busy_cfg = '0;
  logic [3:0]  sl_busy_left = '0;
  logic        sl_err_arm = 1'b0;
  logic [4:0]  sl_err_addr = '0;
  logic        sl_rd_err = 1'b0;
  int          cyc = 0;
  int          log_n = 0;
  logic [4:0]  log_addr [0:31];
  logic        log_wr   [0:31];
  logic [15:0] log_dat  [0:31];
  int          log_cyc  [0:31];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    mg_ack <= 1'b0;
    mg_err <= 1'b0;
    if (mg_req && !mg_ack) begin
      mg_ack <= 1'b1;
      if (log_n < 32) begin
        log_addr[log_n] <= mg_addr;
        log_wr[log_n]   <= mg_write;
        log_dat[log_n]  <= mg_wdata;
        log_cyc[log_n]  <= cyc;
      end
      log_n <= log_n + 1;
      if (mg_write) begin
        if (sl_err_arm && mg_addr == sl_err_addr) begin
          mg_err     <= 1'b1;
          sl_err_arm <= 1'b0;
        end else begin
          sl_regs[mg_addr] <= mg_wdata;
          if (mg_addr == 5'h11) sl_busy_left <= sl_busy_cfg;
        end
      end else begin
        mg_err <= sl_rd_err;
        if (mg_addr == 5'h11) begin
          if (sl_busy_left != 0) begin
            mg_rdata     <= sl_regs[17];
            sl_busy_left <= sl_busy_left - 1'b1;
          end else begin
            mg_rdata <= {sl_regs[17][15:2], 2'b00};
          end
        end else begin
          mg_rdata <= sl_regs[mg_addr];
        end
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  logic        got_err;
  logic [63:0] got_rd;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int nwords(input logic [2:0] sz);
    if (sz <= 3'd1) return 1;
    if (sz == 3'd2) return 2;
    if (sz == 3'd3) return 3;
    return 4;
  endfunction

  function automatic logic [63:0] exp_read(input logic [2:0] sz, input logic [63:0] d);
    case (sz)
      3'd0: return {56'd0, d[7:0]};
      3'd1: return {48'd0, d[15:0]};
      3'd2: return {32'd0, d[31:0]};
      3'd3: return {16'd0, d[47:0]};
      default: return d;
    endcase
  endfunction

  task automatic preload(input logic [63:0] d);
    for (int i = 0; i < 4; i++) sl_regs[24+i] = d[i*16 +: 16];
  endtask

  task automatic run_op(input logic wr, input logic [2:0] sz, input logic [7:0] pg,
                        input logic [7:0] rg, input logic [63:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    log_n     = 0;
    req_write = wr;
    req_size  = sz;
    req_page  = pg;
    req_reg   = rg;
    req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got_err = err;
    got_rd  = rdata;
  endtask

  task automatic quiet_check(input string tag, input int n_before);
    logic seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mg_req) seen = 1'b1;
    end
    chk(tag, {63'd0, seen}, 64'd0);
    chk(tag, 64'(log_n), 64'(n_before));
  endtask

  initial begin
    int    pidx, first_rd;
    vec_t  v;
    for (int i = 0; i < 32; i++) sl_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12 ready after reset", {63'd0, ready}, 64'd1);
    chk("R12 done after reset", {63'd0, done}, 64'd0);
    chk("R12 mg_req after reset", {63'd0, mg_req}, 64'd0);

    // vector walk: R1 R2 R3 R4 R5 R6 R8 R11
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      sl_busy_cfg = v.busy;
      if (v.wr) preload(64'd0); else preload(v.dat);
      run_op(v.wr, v.sz, v.pg, v.rg, v.dat);
      chk($sformatf("R8 vec%0d txn count", k), 64'(log_n), 64'(v.exp_n));
      if (v.exp_pw) begin
        chk($sformatf("R1 R2 vec%0d page addr", k), 64'(log_addr[0]), 64'h10);
        chk($sformatf("R1 vec%0d page word", k), 64'(log_dat[0]), {48'd0, v.pg, 8'h01});
      end else begin
        chk($sformatf("R1 vec%0d no page write", k), {63'd0, log_addr[0] == 5'h10}, 64'd0);
      end
      pidx = (v.exp_pw ? 1 : 0) + (v.wr ? nwords(v.sz) : 0);
      chk($sformatf("R3 R4 vec%0d cmd addr", k), 64'(log_addr[pidx]), 64'h11);
      chk($sformatf("R3 R4 vec%0d cmd word", k), 64'(log_dat[pidx]),
          {48'd0, v.rg, 6'd0, ~v.wr, v.wr});
      if (v.busy >= 5) begin
        chk($sformatf("R6 vec%0d err", k), {63'd0, got_err}, 64'd1);
        chk($sformatf("R6 vec%0d rdata", k), got_rd, 64'd0);
      end else begin
        chk($sformatf("R5 vec%0d err", k), {63'd0, got_err}, 64'd0);
        if (v.wr) begin
          for (int i = 0; i < nwords(v.sz); i++)
            chk($sformatf("R3 vec%0d word%0d", k, i), 64'(sl_regs[24+i]), 64'(v.dat[i*16 +: 16]));
          chk($sformatf("R8 vec%0d write rdata", k), got_rd, 64'd0);
        end else begin
          first_rd = pidx + 1 + int'(v.busy) + 1;
          chk($sformatf("R4 vec%0d first read addr", k), 64'(log_addr[first_rd]),
              64'(5'h18 + 5'(nwords(v.sz) - 1)));
          chk($sformatf("R4 R11 vec%0d rdata", k), got_rd, exp_read(v.sz, v.dat));
        end
      end
    end

    // R7: failed page write, then cache must still miss
    sl_busy_cfg = 0;
    sl_err_addr = 5'h10; sl_err_arm = 1'b1;
    preload(64'h0000_0000_0000_7777);
    run_op(1'b0, 3'd1, 8'h09, 8'h02, 64'd0);
    chk("R7 page fail err", {63'd0, got_err}, 64'd1);
    chk("R7 page fail rdata", got_rd, 64'd0);
    quiet_check("R7 page fail stops", 1);
    run_op(1'b0, 3'd1, 8'h09, 8'h02, 64'd0);
    chk("R7 cache kept old page", 64'(log_addr[0]), 64'h10);
    chk("R7 retry ok rdata", got_rd, 64'h7777);

    // R7: failed data write
    sl_err_addr = 5'h19; sl_err_arm = 1'b1;
    run_op(1'b1, 3'd2, 8'h09, 8'h06, 64'h0000_0000_1357_2468);
    chk("R7 data fail err", {63'd0, got_err}, 64'd1);
    quiet_check("R7 data fail stops", 2);

    // R7: failed command write
    sl_err_addr = 5'h11; sl_err_arm = 1'b1;
    run_op(1'b0, 3'd1, 8'h09, 8'h06, 64'd0);
    chk("R7 cmd fail err", {63'd0, got_err}, 64'd1);
    quiet_check("R7 cmd fail stops", 1);

    // R7: read error flag ignored
    sl_rd_err = 1'b1;
    preload(64'h0000_0000_0000_5A5A);
    run_op(1'b0, 3'd1, 8'h09, 8'h0A, 64'd0);
    chk("R7 read err ignored", {63'd0, got_err}, 64'd0);
    chk("R7 read err data", got_rd, 64'h5A5A);
    sl_rd_err = 1'b0;

    // R5: poll spacing for two gap settings
    for (int g = 0; g < 2; g++) begin
      poll_gap = (g == 0) ? 16'd3 : 16'd9;
      sl_busy_cfg = 2;
      run_op(1'b0, 3'd1, 8'h09, 8'h0A, 64'd0);
      chk($sformatf("R5 poll spacing gap=%0d", poll_gap), 64'(log_cyc[2] - log_cyc[1]),
          64'(poll_gap) + 64'd4);
    end
    sl_busy_cfg = 0;
    poll_gap = 16'd2;

    // R9: request while busy is ignored
    @(negedge clk);
    while (!ready) @(negedge clk);
    log_n = 0;
    req_write = 1'b0; req_size = 3'd1; req_page = 8'h09; req_reg = 8'h0E;
    req_valid = 1'b1;
    @(negedge clk);
    req_page = 8'h3C; req_reg = 8'h50;
    chk("R9 ready low while busy", {63'd0, ready}, 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 first op txn count", 64'(log_n), 64'd3);
    quiet_check("R9 busy request dropped", 3);
    run_op(1'b0, 3'd1, 8'h09, 8'h0E, 64'd0);
    chk("R9 cache not moved by ignored request", {63'd0, log_addr[0] == 5'h10}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule